// File: doc/BRIEF.md
# Burst and Port-Size Bus Sequencer

This block accepts one access request at a time from the processor side and turns it into the series of bus beats that an external bus of 8, 16 or 32 bits needs. A request names a start address, a transfer size (byte, word, longword or a 16-byte line) and a direction. For every beat the block presents an address, active-low byte-lane strobes and the direction. It holds each beat until an acknowledge arrives. The time between acknowledges is set by whatever sits on the far side of the bus.

A line transfer covers a 16-byte block as four longwords. It may start at any longword in the block. The low four address bits then count upward and wrap within the block. On a narrow port, every longword is also split into half-word or byte beats. The port width is a configuration input that is captured when a request is accepted. Requests that break the alignment rule are refused with an error pulse and produce no beats.

Top module: `bus_beat_sequencer`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, `bus_active`, `bus_last`, `xfer_done` and `xfer_err` are 0, and `bus_be_n` is 4'b1111.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 while a transfer is in progress, and `req_valid` asserted during a transfer has no effect.
- R3: The number of beats equals the transfer bytes (size code 00=1, 01=2, 10=4, 11=16) divided by the beat width. The beat width is the smaller of the transfer bytes and the port bytes.
- R4: The first beat appears in the cycle after acceptance at the request address. The address and strobes only change after a clock edge with `bus_ack` high, and then the address advances by the beat width.
- R5: The beat address advances modulo 16 in bits 3:0, and all higher address bits stay fixed, so a line wraps within its aligned 16-byte block.
- R6: `bus_be_n[k]` is 0 exactly when byte lane k, with k equal to address bits 1:0 of a byte, lies inside the current beat (from `bus_addr[1:0]` for beat-width bytes). All strobes are 1 when no beat is active.
- R7: `bus_last` is 1 on the final beat only. `xfer_done` is a one-cycle pulse in the cycle after that beat's acknowledge, and the block is idle in that cycle.
- R8: A word request with address bit 0 set, or a longword or line request with either of address bits 1:0 set, produces a one-cycle `xfer_err` pulse in the cycle after acceptance, no beats and no `xfer_done`.
- R9: `bus_write` equals the `req_write` captured at acceptance and holds for the whole transfer.
- R10: `port_size` is sampled at acceptance. Changing it during a transfer does not alter the remaining beats.
- R11: Port code 00 selects 32 bits, 01 selects 8 bits and 10 selects 16 bits. The unused code 11 behaves as 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | 2 | 00 byte, 01 word, 10 longword, 11 line |
| req_write | input | 1 | 1 for a write, 0 for a read |
| port_size | input | 2 | 00 32-bit, 01 8-bit, 10 16-bit, 11 as 32-bit |
| bus_addr | output | ADDR_W | Address of the current beat |
| bus_be_n | output | 4 | Active-low byte-lane strobes |
| bus_write | output | 1 | Direction of the current transfer |
| bus_active | output | 1 | A beat is being presented |
| bus_last | output | 1 | Current beat is the final one |
| bus_ack | input | 1 | Beat acknowledge from the bus side |
| xfer_done | output | 1 | One-cycle pulse after the last acknowledge |
| xfer_err | output | 1 | One-cycle pulse for a refused misaligned request |

## Verification
The hardest case to reach from the ports is a line on a byte-wide port that starts in the last longword of its block. Acknowledges arrive with gaps, and a new request and a different port width are offered halfway through the burst. All sixteen wrapped beats must still come out unchanged. The stimulus drives acknowledges through an adjustable gap pattern. It raises a competing `req_valid` and switches `port_size` in the first beats of the burst. A behavioural model builds the expected beat list at acceptance and is compared with the outputs on every clock.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        PORT_32  = 2'b00,
        PORT_8   = 2'b01,
        PORT_16  = 2'b10,
        PORT_RSV = 2'b11
    } port_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BEAT = 1'b1
    } seq_state_e;

endpackage

// File: rtl/bbs_beat_plan.sv
module bbs_beat_plan
    import bbs_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int LINE_BYTES = 16,
    localparam int LO_W      = $clog2(LANES),
    localparam int STEP_W    = LO_W + 1,
    localparam int CNT_W     = $clog2(LINE_BYTES) + 1,
    localparam int LG_W      = $clog2(CNT_W) + 1
) (
    input  logic [1:0]        size_i,
    input  logic [1:0]        port_i,
    input  logic [LO_W-1:0]   addr_lo_i,
    output logic [STEP_W-1:0] step_o,
    output logic [CNT_W-1:0]  beats_o,
    output logic              misaligned_o
);

    logic [LG_W-1:0] port_lg;
    logic [LG_W-1:0] total_lg;
    logic [LG_W-1:0] step_lg;

    always_comb begin
        case (port_size_e'(port_i))
            PORT_8:  port_lg = LG_W'(0);
            PORT_16: port_lg = LG_W'(1);
            default: port_lg = LG_W'(LO_W);
        endcase

        case (xfer_size_e'(size_i))
            SZ_BYTE: total_lg = LG_W'(0);
            SZ_WORD: total_lg = LG_W'(1);
            SZ_LONG: total_lg = LG_W'(LO_W);
            default: total_lg = LG_W'($clog2(LINE_BYTES));
        endcase

        step_lg = (port_lg < total_lg) ? port_lg : total_lg;
        step_o  = STEP_W'(1) << step_lg;
        beats_o = CNT_W'(1) << (total_lg - step_lg);

        case (xfer_size_e'(size_i))
            SZ_WORD: misaligned_o = addr_lo_i[0];
            SZ_LONG,
            SZ_LINE: misaligned_o = |addr_lo_i;
            default: misaligned_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bbs_lane_mask.sv
module bbs_lane_mask #(
    parameter int LANES   = 4,
    localparam int LO_W   = $clog2(LANES),
    localparam int STEP_W = LO_W + 1,
    localparam int EXT_W  = STEP_W + 1
) (
    input  logic              enable_i,
    input  logic [LO_W-1:0]   addr_lo_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [LANES-1:0]  be_n_o
);

    logic [EXT_W-1:0] lo_ext;
    logic [EXT_W-1:0] hi_ext;

    assign lo_ext = EXT_W'(addr_lo_i);
    assign hi_ext = EXT_W'(addr_lo_i) + EXT_W'(step_i);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic covered;
        assign covered   = (EXT_W'(k) >= lo_ext) && (EXT_W'(k) < hi_ext);
        assign be_n_o[k] = ~(enable_i & covered);
    end

endmodule

// File: rtl/bus_beat_sequencer.sv
module bus_beat_sequencer
    import bbs_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int LANES      = 4,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [1:0]        port_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [LANES-1:0]  bus_be_n,
    output logic              bus_write,
    output logic              bus_active,
    output logic              bus_last,
    input  logic              bus_ack,
    output logic              xfer_done,
    output logic              xfer_err
);

    localparam int LO_W   = $clog2(LANES);
    localparam int STEP_W = LO_W + 1;
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int CNT_W  = OFS_W + 1;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [STEP_W-1:0] step;
        logic [CNT_W-1:0]  left;
        logic              wr;
        logic              done;
        logic              err;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [STEP_W-1:0] plan_step;
    logic [CNT_W-1:0]  plan_beats;
    logic              plan_mis;

    bbs_beat_plan #(
        .LANES      (LANES),
        .LINE_BYTES (LINE_BYTES)
    ) u_plan (
        .size_i       (req_size),
        .port_i       (port_size),
        .addr_lo_i    (req_addr[LO_W-1:0]),
        .step_o       (plan_step),
        .beats_o      (plan_beats),
        .misaligned_o (plan_mis)
    );

    // Next-state logic
    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (plan_mis) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.st   = ST_BEAT;
                        seq_d.addr = req_addr;
                        seq_d.step = plan_step;
                        seq_d.left = plan_beats;
                        seq_d.wr   = req_write;
                    end
                end
            end
            default: begin
                if (bus_ack) begin
                    if (seq_q.left == CNT_W'(1)) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        // only the in-line offset moves; it wraps inside the block
                        seq_d.addr[OFS_W-1:0] = seq_q.addr[OFS_W-1:0] + OFS_W'(seq_q.step);
                        seq_d.left            = seq_q.left - CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, addr: '0, step: '0, left: '0,
                       wr: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready  = (seq_q.st == ST_IDLE);
    assign bus_active = (seq_q.st == ST_BEAT);
    assign bus_last   = bus_active && (seq_q.left == CNT_W'(1));
    assign bus_addr   = seq_q.addr;
    assign bus_write  = seq_q.wr;
    assign xfer_done  = seq_q.done;
    assign xfer_err   = seq_q.err;

    bbs_lane_mask #(
        .LANES (LANES)
    ) u_lanes (
        .enable_i  (bus_active),
        .addr_lo_i (seq_q.addr[LO_W-1:0]),
        .step_i    (seq_q.step),
        .be_n_o    (bus_be_n)
    );

    // R2: never ready while a beat is on the bus
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |-> !req_ready);

    // R4: beat held until acknowledged
    a_r4_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && !bus_ack) |=> (bus_active && $stable(bus_addr) && $stable(bus_be_n)));

    // R5: upper address bits fixed across a beat advance
    a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && bus_ack && !bus_last) |=>
            (bus_addr[ADDR_W-1:OFS_W] == $past(bus_addr[ADDR_W-1:OFS_W])));

    // R6: strobes quiet when idle, at least one lane when active
    a_r6_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_active |-> (bus_be_n == {LANES{1'b1}}));
    a_r6_strobe_active: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |-> (bus_be_n != {LANES{1'b1}}));

    // R7: final acknowledge ends the transfer with a done pulse
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && bus_ack && bus_last) |=> (xfer_done && !bus_active));
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R8: an error never coincides with beats or completion
    a_r8_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> (!bus_active && !xfer_done));

    // R9: direction stable within a transfer
    a_r9_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_active && !(bus_ack && bus_last)) |=> $stable(bus_write));

endmodule

// File: tb/bus_beat_sequencer_bench.sv
module bus_beat_sequencer_bench;

    localparam int AW = 23;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'b00;
    logic          req_write = 1'b0;
    logic [1:0]    port_size = 2'b00;
    logic [AW-1:0] bus_addr;
    logic [3:0]    bus_be_n;
    logic          bus_write;
    logic          bus_active;
    logic          bus_last;
    logic          bus_ack = 1'b0;
    logic          xfer_done;
    logic          xfer_err;

    always #10 clk = ~clk;

    bus_beat_sequencer #(.ADDR_W(AW)) u_bus_beat_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_write  (req_write),
        .port_size  (port_size),
        .bus_addr   (bus_addr),
        .bus_be_n   (bus_be_n),
        .bus_write  (bus_write),
        .bus_active (bus_active),
        .bus_last   (bus_last),
        .bus_ack    (bus_ack),
        .xfer_done  (xfer_done),
        .xfer_err   (xfer_err)
    );

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int dut_beats = 0;
    bit compare_on = 1'b0;

    // reference model state
    bit            m_active = 1'b0;
    bit            m_done = 1'b0;
    bit            m_err = 1'b0;
    bit            m_write = 1'b0;
    bit            m_line = 1'b0;
    logic [AW-1:0] qa[$];
    logic [3:0]    qb[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    function automatic int bytes_of(input logic [1:0] sz);
        case (sz)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 16;
        endcase
    endfunction

    function automatic int port_bytes(input logic [1:0] p);
        if (p == 2'b01) return 1;
        if (p == 2'b10) return 2;
        return 4;
    endfunction

    function automatic bit is_bad(input logic [1:0] sz, input logic [AW-1:0] a);
        if (sz == 2'b01) return a[0];
        if (sz == 2'b10 || sz == 2'b11) return a[1:0] != 2'b00;
        return 1'b0;
    endfunction

    function automatic int expect_beats(input logic [1:0] sz, input logic [1:0] p, input logic [AW-1:0] a);
        int t, w;
        if (is_bad(sz, a)) return 0;
        t = bytes_of(sz);
        w = (port_bytes(p) < t) ? port_bytes(p) : t;
        return t / w;
    endfunction

    // builds the expected beat list at acceptance
    task automatic model_accept();
        int t, w, n, off;
        logic [3:0] be;
        t = bytes_of(req_size);
        w = (port_bytes(port_size) < t) ? port_bytes(port_size) : t;
        n = t / w;
        for (int i = 0; i < n; i++) begin
            off = (int'(req_addr[3:0]) + i * w) % 16;
            qa.push_back({req_addr[AW-1:4], 4'(off)});
            for (int k = 0; k < 4; k++)
                be[k] = !((k >= off % 4) && (k < off % 4 + w));
            qb.push_back(be);
        end
        m_active = 1'b1;
        m_write  = req_write;
        m_line   = (req_size == 2'b11);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (bus_active && bus_ack) dut_beats++;
        m_done = 1'b0;
        m_err  = 1'b0;
        if (!rst_n) begin
            m_active = 1'b0;
            qa.delete();
            qb.delete();
        end else if (m_active) begin
            if (bus_ack) begin
                void'(qa.pop_front());
                void'(qb.pop_front());
                if (qa.size() == 0) begin
                    m_active = 1'b0;
                    m_done   = 1'b1;
                end
            end
        end else if (req_valid) begin
            if (is_bad(req_size, req_addr)) m_err = 1'b1;
            else model_accept();
        end
        if (cyc > 20000) begin
            total++;
            fails++;
            $display("FAIL watchdog R7: actual=%0d cycles expected=done", cyc);
            report();
            $finish;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (compare_on && rst_n) begin
            check(req_ready == !m_active, "R2 ready", 32'(req_ready), 32'(!m_active));
            check(bus_active == m_active, "R3 active", 32'(bus_active), 32'(m_active));
            check(xfer_done == m_done, "R7 done", 32'(xfer_done), 32'(m_done));
            check(xfer_err == m_err, "R8 err", 32'(xfer_err), 32'(m_err));
            if (m_active) begin
                if (m_line) check(bus_addr == qa[0], "R5 line addr", 32'(bus_addr), 32'(qa[0]));
                else        check(bus_addr == qa[0], "R4 addr", 32'(bus_addr), 32'(qa[0]));
                check(bus_be_n == qb[0], "R6 strobes", 32'(bus_be_n), 32'(qb[0]));
                check(bus_last == (qa.size() == 1), "R7 last", 32'(bus_last), 32'(qa.size() == 1));
                check(bus_write == m_write, "R9 write", 32'(bus_write), 32'(m_write));
            end else begin
                check(bus_be_n == 4'hF, "R6 idle strobes", 32'(bus_be_n), 32'hF);
                check(!bus_last, "R7 idle last", 32'(bus_last), 32'h0);
            end
        end
    end

    task automatic run_xfer(input logic [AW-1:0] a, input logic [1:0] sz, input bit wr,
                            input logic [1:0] p, input int gap, input bit disturb, input string tag);
        int n_exp, guard;
        n_exp = expect_beats(sz, p, a);
        @(negedge clk);
        dut_beats = 0;
        req_addr  = a;
        req_size  = sz;
        req_write = wr;
        port_size = p;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (m_active && guard < 400) begin
            bus_ack = (gap == 0) ? 1'b1 : ((guard % (gap + 1)) == gap);
            if (disturb && guard == 0) begin
                // R2 competing request and R10 port change during the burst
                req_valid = 1'b1;
                req_addr  = 23'h000100;
                req_size  = 2'b00;
                req_write = ~wr;
                port_size = 2'b00;
            end
            if (disturb && guard == 1) req_valid = 1'b0;
            @(negedge clk);
            guard++;
        end
        bus_ack   = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        check(dut_beats == n_exp, tag, 32'(dut_beats), 32'(n_exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'h1);
        check(bus_active == 1'b0, "R1 active", 32'(bus_active), 32'h0);
        check(bus_be_n == 4'hF, "R1 strobes", 32'(bus_be_n), 32'hF);
        check(!xfer_done && !xfer_err && !bus_last, "R1 pulses",
              32'({xfer_done, xfer_err, bus_last}), 32'h0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        @(negedge clk);
        // acknowledge with nothing in flight has no effect (R2)
        bus_ack = 1'b1;
        @(negedge clk);
        bus_ack = 1'b0;
        @(negedge clk);

        run_xfer(23'h000003, 2'b00, 1'b0, 2'b00, 0, 1'b0, "R3 byte on 32-bit");
        run_xfer(23'h000012, 2'b01, 1'b1, 2'b00, 1, 1'b0, "R3 word on 32-bit");
        run_xfer(23'h000020, 2'b10, 1'b0, 2'b00, 2, 1'b0, "R3 long on 32-bit");
        run_xfer(23'h000036, 2'b01, 1'b1, 2'b01, 0, 1'b0, "R3 word on 8-bit");
        run_xfer(23'h000044, 2'b10, 1'b0, 2'b01, 1, 1'b0, "R3 long on 8-bit");
        run_xfer(23'h000058, 2'b10, 1'b1, 2'b10, 0, 1'b0, "R3 long on 16-bit");
        run_xfer(23'h000063, 2'b00, 1'b0, 2'b01, 0, 1'b0, "R3 byte on 8-bit");
        run_xfer(23'h000000, 2'b11, 1'b0, 2'b00, 0, 1'b0, "R3 line on 32-bit");
        run_xfer(23'h12345C, 2'b11, 1'b1, 2'b00, 0, 1'b0, "R5 line wrap from last longword");
        run_xfer(23'h7FFFF4, 2'b11, 1'b0, 2'b10, 1, 1'b0, "R5 line wrap on 16-bit");
        run_xfer(23'h0ABC08, 2'b11, 1'b1, 2'b01, 2, 1'b0, "R5 line wrap on 8-bit");
        run_xfer(23'h00007C, 2'b11, 1'b0, 2'b01, 1, 1'b1, "R10 port change mid-line");
        run_xfer(23'h000084, 2'b10, 1'b1, 2'b11, 0, 1'b0, "R11 reserved port as 32-bit");
        run_xfer(23'h000091, 2'b01, 1'b0, 2'b00, 0, 1'b0, "R8 misaligned word");
        run_xfer(23'h0000A2, 2'b10, 1'b1, 2'b01, 0, 1'b0, "R8 misaligned long");
        run_xfer(23'h0000B6, 2'b11, 1'b0, 2'b10, 0, 1'b0, "R8 misaligned line");
        run_xfer(23'h0000C4, 2'b11, 1'b1, 2'b10, 3, 1'b1, "R9 write held with disturbance");

        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule